// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two square N×N matrices of signed 8-bit integers on an N×N grid of multiply-accumulate cells. Each cell owns one element of the result C = A×B. That element's 32-bit accumulator stays inside its cell for the whole product. Both operand matrices flow through the grid and neither is preloaded. Values of A travel rightwards and values of B travel downwards, one cell per step. Each cell adds the product of the two operands it currently sees to its own accumulator. No partial sum crosses a cell boundary while the grid is computing.

A run begins with a `start` pulse while the block is idle. This clears every accumulator and opens the operand stream. The operand stream carries one beat per index k. A beat holds column k of A and row k of B, side by side and unskewed. The block skews them internally: row r of A is delayed by r steps and column c of B by c steps. After N beats the block inserts 2N-2 steps of zero operands so that the last products can reach the far corner. It then unloads the pinned accumulators through the column chain, one row of N results per beat, on a result stream. A one-cycle `done` pulse closes the run.

Both data streams follow valid/ready rules. An operand beat is taken on a cycle where `in_valid` and `in_ready` are both high. When `in_valid` is low during loading, the whole grid holds. A result beat is offered with `out_valid` and completes when `out_ready` is high. While `out_ready` stays low, the offered beat holds unchanged.

Top module: `osmm_array`

## Requirements
- R1: While reset is active and after it is released, `in_ready`, `out_valid` and `done` are low.
- R2: A `start` pulse while idle raises `in_ready` on the next cycle and clears every accumulator, so results of an earlier run never leak into the next one.
- R3: Exactly N operand beats are taken per run, each only on a cycle with `in_valid` and `in_ready` both high. Beat k carries A[r][k] in `in_a[8r+7:8r]` and B[k][c] in `in_b[8c+7:8c]`. Idle cycles with `in_valid` low between beats do not change the result, and `in_valid` is ignored while idle.
- R4: The results equal the exact integer product C[r][c] = Σk A[r][k]·B[k][c]. The operands are signed two's complement 8-bit values and the results are signed 32-bit values.
- R5: The result stream delivers N beats, row 0 first. Beat r carries C[r][c] in `out_row[32c+31:32c]`, and `out_last` is high on beat N-1 only.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_row` hold their values.
- R7: With no gaps in the operand stream, `out_valid` first rises exactly 3N-2 cycles after `in_ready` rises.
- R8: `done` is high for exactly the one cycle after the last result beat is accepted, and the block is then idle again, with `in_ready` and `out_valid` low.
- R9: A `start` pulse while a run is in progress, during loading or during draining, has no effect on that run.
- R10: `in_ready` and `out_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a run; honoured only while idle |
| done | output | 1 | One-cycle pulse after the last result beat |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Block accepts an operand beat |
| in_a | input | N*8 | Column k of A; lane r is row r |
| in_b | input | N*8 | Row k of B; lane c is column c |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_row | output | N*32 | One result row; lane c is column c |
| out_last | output | 1 | Marks the final result beat |

## Verification
The sweep first uses structured matrices. An identity A exposes any mix-up of lanes or rows, because C must reproduce B exactly. Matrices filled with the extreme values +127 and -128 expose sign-extension and width faults in the products and the sums. The sweep then runs dozens of pseudo-random signed matrices in several traffic modes. Unbroken streams pin down the 3N-2 latency. Random gaps on `in_valid` and `out_ready` reveal cells that advance when they should hold. Stray `start` pulses and idle-time `in_valid` reveal a controller that restarts or accepts beats when it must not.

// File: rtl/osmm_pkg.sv
package osmm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_FLUSH = 2'd2,
    ST_DRAIN = 2'd3
  } osmm_state_e;
endpackage

// File: rtl/osmm_skew.sv
// Per-lane delay line: lane r is delayed by r steps; it advances only on step.
module osmm_skew #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [N*W-1:0] lanes_i,
  output logic [N*W-1:0] lanes_o
);
  for (genvar r = 0; r < N; r++) begin : g_lane
    if (r == 0) begin : g_direct
      assign lanes_o[W-1:0] = lanes_i[W-1:0];
    end else begin : g_delay
      logic [W-1:0] dly [r];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int j = 0; j < r; j++) dly[j] <= '0;
        end else if (clr) begin
          for (int j = 0; j < r; j++) dly[j] <= '0;
        end else if (step) begin
          dly[0] <= lanes_i[r*W +: W];
          for (int j = 1; j < r; j++) dly[j] <= dly[j-1];
        end
      end
      assign lanes_o[r*W +: W] = dly[r-1];
    end
  end
endmodule

// File: rtl/osmm_pe.sv
// One grid cell: passes operands east/south and keeps a pinned accumulator.
// During drain the accumulator takes the value of the cell below it.
module osmm_pe #(
  parameter int AW = 8,
  parameter int CW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 step,
  input  logic                 shift,
  input  logic signed [AW-1:0] a_i,
  input  logic signed [AW-1:0] b_i,
  output logic signed [AW-1:0] a_o,
  output logic signed [AW-1:0] b_o,
  input  logic signed [CW-1:0] acc_i,
  output logic signed [CW-1:0] acc_o
);
  localparam int PW = 2 * AW;

  logic signed [PW-1:0] prod;
  logic signed [CW-1:0] prod_ext;

  assign prod     = a_i * b_i;
  assign prod_ext = {{(CW-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_o   <= '0;
      b_o   <= '0;
      acc_o <= '0;
    end else if (clr) begin
      a_o   <= '0;
      b_o   <= '0;
      acc_o <= '0;
    end else if (step) begin
      a_o   <= a_i;
      b_o   <= b_i;
      acc_o <= acc_o + prod_ext;
    end else if (shift) begin
      acc_o <= acc_i;
    end
  end

  // R4: accumulation and unloading never overlap in a cell
  assert_step_shift_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(step && shift));
endmodule

// File: rtl/osmm_ctrl.sv
// Run sequencer: idle -> load N beats -> flush 2N-2 steps -> drain N rows.
module osmm_ctrl
  import osmm_pkg::*;
#(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic out_last,
  output logic done,
  output logic clr,
  output logic step,
  output logic feed,
  output logic shift
);
  localparam int FLUSH_STEPS = 2 * N - 2;
  localparam int FL_LAST     = (FLUSH_STEPS > 0) ? FLUSH_STEPS - 1 : 0;
  localparam int CNTW        = $clog2(2 * N + 1);

  osmm_state_e state;
  logic [CNTW-1:0] cnt;

  assign in_ready  = (state == ST_LOAD);
  assign out_valid = (state == ST_DRAIN);
  assign out_last  = out_valid && (cnt == CNTW'(N - 1));
  assign feed      = (state == ST_LOAD);
  assign step      = (in_ready && in_valid) || (state == ST_FLUSH);
  assign shift     = out_valid && out_ready;
  assign clr       = start && (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_LOAD;
            cnt   <= '0;
          end
        end
        ST_LOAD: begin
          if (in_valid) begin
            if (cnt == CNTW'(N - 1)) begin
              cnt   <= '0;
              state <= (FLUSH_STEPS == 0) ? ST_DRAIN : ST_FLUSH;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_FLUSH: begin
          if (cnt == CNTW'(FL_LAST)) begin
            cnt   <= '0;
            state <= ST_DRAIN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (out_ready) begin
            if (cnt == CNTW'(N - 1)) begin
              cnt   <= '0;
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: loading opens only in answer to a start pulse
  assert_load_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(start));
  // R8: done lasts a single cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: a start during a stalled drain leaves the drain in place
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRAIN && start && !out_ready) |=> (state == ST_DRAIN) && $stable(cnt));
  // R5: row index stays within the grid during drain
  assert_drain_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cnt < CNTW'(N)));
endmodule

// File: rtl/osmm_array.sv
module osmm_array #(
  parameter int N  = 4,
  parameter int AW = 8,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          done,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [N*AW-1:0] in_a,
  input  logic [N*AW-1:0] in_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [N*CW-1:0] out_row,
  output logic          out_last
);
  localparam int LW = N * AW;

  logic clr, step, feed, shift;
  logic [LW-1:0] a_src, b_src, a_sk, b_sk;

  assign a_src = feed ? in_a : '0;
  assign b_src = feed ? in_b : '0;

  osmm_ctrl #(.N(N)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .done      (done),
    .clr       (clr),
    .step      (step),
    .feed      (feed),
    .shift     (shift)
  );

  osmm_skew #(.N(N), .W(AW)) u_skew_a (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(step),
    .lanes_i(a_src), .lanes_o(a_sk)
  );

  osmm_skew #(.N(N), .W(AW)) u_skew_b (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(step),
    .lanes_i(b_src), .lanes_o(b_sk)
  );

  logic signed [AW-1:0] a_q   [N][N];
  logic signed [AW-1:0] b_q   [N][N];
  logic signed [CW-1:0] acc_q [N][N];

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      logic signed [AW-1:0] a_w, b_n;
      logic signed [CW-1:0] acc_s;

      if (c == 0) begin : g_west_edge
        assign a_w = a_sk[r*AW +: AW];
      end else begin : g_west_cell
        assign a_w = a_q[r][c-1];
      end

      if (r == 0) begin : g_north_edge
        assign b_n = b_sk[c*AW +: AW];
      end else begin : g_north_cell
        assign b_n = b_q[r-1][c];
      end

      if (r == N - 1) begin : g_south_edge
        assign acc_s = '0;
      end else begin : g_south_cell
        assign acc_s = acc_q[r+1][c];
      end

      osmm_pe #(.AW(AW), .CW(CW)) u_pe (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .step  (step),
        .shift (shift),
        .a_i   (a_w),
        .b_i   (b_n),
        .a_o   (a_q[r][c]),
        .b_o   (b_q[r][c]),
        .acc_i (acc_s),
        .acc_o (acc_q[r][c])
      );
    end
  end

  for (genvar c = 0; c < N; c++) begin : g_out
    assign out_row[c*CW +: CW] = acc_q[0][c];
  end

  // R6: an offered result holds under back-pressure
  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_row));
  // R8: accepting the final row is followed by done
  assert_last_then_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> done);
  // R10: the two streams are never active together
  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
endmodule

// File: tb/tb_osmm_array.sv
`timescale 1ns/1ps
module tb_osmm_array;
  localparam int N  = 4;
  localparam int AW = 8;
  localparam int CW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [N*AW-1:0] in_a = '0;
  logic [N*AW-1:0] in_b = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [N*CW-1:0] out_row;
  logic out_last;

  always #2 clk = ~clk;

  osmm_array #(.N(N), .AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
    .out_last(out_last)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [31:0] seed = 32'h1234_5679;
  int ma [N][N];
  int mb [N][N];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic run_case(input bit in_gaps, input bit out_gaps,
                          input bit poke_start, input bit idle_junk);
    int exp_c [N][N];
    int k, row, t_in, t_out, guard;
    bit held, fire;
    logic [N*CW-1:0] held_row;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        exp_c[r][c] = 0;
        for (int x = 0; x < N; x++) exp_c[r][c] += ma[r][x] * mb[x][c];
      end
    if (idle_junk) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_a = rnd(); in_b = rnd();
        chk(in_ready == 1'b0, "R3", "in_ready while idle", in_ready, 0);
      end
    end
    @(negedge clk); in_valid = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(in_ready == 1'b1, "R2", "in_ready after start", in_ready, 1);
    t_in = cyc;
    k = 0; guard = 0;
    while (k < N && guard < 500) begin
      guard++;
      if (in_gaps && rnd() % 3 == 0) begin
        in_valid = 1'b0;
        in_a = rnd(); in_b = rnd();
      end else begin
        in_valid = 1'b1;
        for (int i = 0; i < N; i++) begin
          in_a[i*AW +: AW] = ma[i][k][AW-1:0];
          in_b[i*AW +: AW] = mb[k][i][AW-1:0];
        end
      end
      start = poke_start && (k == 1);  // R9: start during loading
      if (out_valid) chk(1'b0, "R10", "out_valid while loading", 1, 0);
      fire = in_valid && in_ready;
      @(negedge clk);
      if (fire) k++;
    end
    in_valid = 1'b0; start = 1'b0;
    row = 0; held = 1'b0; t_out = -1; guard = 0;
    while (row < N && guard < 500) begin
      guard++;
      if (out_valid && t_out < 0) t_out = cyc;
      if (held)
        chk(out_valid == 1'b1 && out_row == held_row, "R6", "hold under back-pressure",
            longint'(out_row[CW-1:0]), longint'(held_row[CW-1:0]));
      out_ready = out_gaps ? rnd() % 2 == 0 : 1'b1;
      start = poke_start && (row == 1);  // R9: start during draining
      if (out_valid && in_ready) chk(1'b0, "R10", "both streams active", 1, 0);
      if (out_valid && out_ready) begin
        for (int c = 0; c < N; c++)
          chk($signed(out_row[c*CW +: CW]) == exp_c[row][c], "R4",
              $sformatf("C[%0d][%0d]", row, c),
              $signed(out_row[c*CW +: CW]), exp_c[row][c]);
        chk(out_last == (row == N - 1), "R5", $sformatf("out_last row %0d", row),
            out_last, row == N - 1);
        row++;
      end
      held = out_valid && !out_ready;
      held_row = out_row;
      @(negedge clk);
    end
    if (guard >= 500) chk(1'b0, "R5", "drain stalled", row, N);
    out_ready = 1'b0; start = 1'b0;
    chk(done == 1'b1, "R8", "done after last beat", done, 1);
    if (!in_gaps)
      chk(t_out - t_in == 3 * N - 2, "R7", "latency", t_out - t_in, 3 * N - 2);
    @(negedge clk);
    chk(done == 1'b0 && in_ready == 1'b0 && out_valid == 1'b0, "R8", "idle after done",
        {done, in_ready, out_valid}, 0);
  endtask

  task automatic fill_rand();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        ma[r][c] = $signed(rnd() & 32'hFF) - ((rnd() & 1) ? 0 : 0);
        ma[r][c] = ma[r][c] > 127 ? ma[r][c] - 256 : ma[r][c];
        mb[r][c] = int'(rnd() & 32'hFF);
        mb[r][c] = mb[r][c] > 127 ? mb[r][c] - 256 : mb[r][c];
      end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 0 && out_valid == 0 && done == 0, "R1", "outputs in reset",
        {in_ready, out_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 0 && out_valid == 0 && done == 0, "R1", "outputs after reset",
        {in_ready, out_valid, done}, 0);
    // identity A: C must equal B (lane/row mapping)
    fill_rand();
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) ma[r][c] = (r == c) ? 1 : 0;
    run_case(1'b0, 1'b0, 1'b0, 1'b1);
    // extremes: products and sums at their largest magnitudes
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) begin ma[r][c] = 127; mb[r][c] = 127; end
    run_case(1'b0, 1'b0, 1'b0, 1'b0);
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) begin ma[r][c] = -128; mb[r][c] = -128; end
    run_case(1'b0, 1'b1, 1'b0, 1'b0);
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) begin ma[r][c] = -128; mb[r][c] = 127; end
    run_case(1'b1, 1'b0, 1'b0, 1'b0);
    // pseudo-random sweep over traffic modes; runs follow each other so R2 clearing is exercised
    for (int t = 0; t < 48; t++) begin
      fill_rand();
      run_case(t[0], t[1], t[2], t[3]);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule